// File: doc/BRIEF.md
# Pipelined Amplitude Modulation Multiplier

This block scales one waveform sample by another so that a carrier from the first channel can be amplitude modulated by the waveform of the second channel. The modulation is done in arithmetic rather than by switching the output attenuator, because switching the attenuator produces glitches. The attenuator stays in place and still selects the overall level. Both samples are unsigned. The carrier code at half scale stands for zero signal. The modulating sample acts as a gain between zero and almost one.

A single-cycle full-width multiply cannot reach the sample rate, so the product is built over a chain of registered stages. Each stage looks at one bit of the modulator and adds a shifted copy of the signed carrier offset to a running sum. The sum, the offset and the bits still to be used move on to the next stage. The block takes one sample pair on every clock and returns one result on every clock. After the last stage, a registered rescale step turns the sum back into an unsigned sample centred on half scale.

Top module: `amod_pipe_mult`

## Requirements
- R1: With carrier c and modulator m (12-bit unsigned each), the result is 2048 + floor((c - 2048) * m / 4096), where floor rounds toward minus infinity.
- R2: A result appears with `prod_valid` high exactly 13 rising clock edges after the edge that sampled `samp_valid` high. That is 12 bit stages plus one output register.
- R3: Sample pairs presented on consecutive clocks produce results on consecutive clocks, in the order they were taken, with none lost.
- R4: A clock with `samp_valid` low produces no result. The number of results equals the number of accepted pairs.
- R5: A synchronous reset clears every valid bit in the pipeline and sets `prod_sample` to 2048. No result appears from pairs that were in flight when reset was applied.
- R6: A modulator of 0 gives 2048 for any carrier.
- R7: A carrier of 2048 gives 2048 for any modulator.
- R8: The result never exceeds 4094. Carrier 0 with modulator 4095 gives 0, and carrier 4095 with modulator 4095 gives 4094.
- R9: `prod_sample` holds its last value while `prod_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_valid | input | 1 | Carrier and modulator are valid this clock |
| carrier_in | input | 12 | Unsigned carrier sample, 2048 is zero signal |
| modulator_in | input | 12 | Unsigned modulating sample, used as gain m/4096 |
| prod_valid | output | 1 | Result valid |
| prod_sample | output | 12 | Modulated unsigned sample |

## Verification
The bench targets negative offsets whose product is not a multiple of 4096, such as carrier 0 with modulator 1, which must give 2047. A design that truncates toward zero would return 2048 there. It also drives the extreme corners: full-scale carrier times full-scale modulator must land on 0 and 4094. A sign-extension or midpoint-restore error would wrap these corners to the wrong end of the range. Back-to-back streams, streams with gaps, and a reset with pairs still in flight show whether a design drops, duplicates or shifts results by a clock, or lets stale results escape after reset.

// File: rtl/amod_pkg.sv
package amod_pkg;
  localparam int unsigned AMOD_SAMPLE_W = 12;
  typedef logic [AMOD_SAMPLE_W-1:0] amod_sample_t;
endpackage

// File: rtl/amod_offset_conv.sv
module amod_offset_conv #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0]        carrier,
  output logic signed [W-1:0] offset
);
  // unsigned code minus half scale equals flipping the top bit
  function automatic logic signed [W-1:0] to_offset(input logic [W-1:0] c);
    return {~c[W-1], c[W-2:0]};
  endfunction

  always_comb offset = to_offset(carrier);
endmodule

// File: rtl/amod_mac_stage.sv
module amod_mac_stage #(
  parameter int unsigned W     = 12,
  parameter int unsigned ACC_W = 24,
  parameter int unsigned BIT   = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_v,
  input  logic signed [ACC_W-1:0] in_acc,
  input  logic signed [W-1:0]     in_off,
  input  logic [W-1:0]            in_mrem,
  output logic                    out_v,
  output logic signed [ACC_W-1:0] out_acc,
  output logic signed [W-1:0]     out_off,
  output logic [W-1:0]            out_mrem
);
  // one shifted carrier term, or nothing, per stage
  function automatic logic signed [ACC_W-1:0] term(input logic signed [W-1:0] off,
                                                   input logic take);
    logic signed [ACC_W-1:0] ext;
    ext = ACC_W'(off);
    return take ? (ext <<< BIT) : '0;
  endfunction

  logic stage_adds;
  assign stage_adds = in_v & in_mrem[0];

  always_ff @(posedge clk) begin
    if (rst) out_v <= 1'b0;
    else     out_v <= in_v;
    out_acc  <= in_acc + term(in_off, stage_adds);
    out_off  <= in_off;
    out_mrem <= in_mrem >> 1;
  end

  assert_valid_advance_R2: assert property (@(posedge clk) disable iff (rst)
    in_v |=> out_v);
  assert_bubble_advance_R4: assert property (@(posedge clk) disable iff (rst)
    !in_v |=> !out_v);
  assert_zero_bit_keeps_sum_R1: assert property (@(posedge clk) disable iff (rst)
    (in_v && !in_mrem[0]) |=> (out_acc == $past(in_acc)));
  assert_offset_carried_R1: assert property (@(posedge clk) disable iff (rst)
    in_v |=> (out_off == $past(in_off)));
endmodule

// File: rtl/amod_rescale_out.sv
module amod_rescale_out #(
  parameter int unsigned W     = 12,
  parameter int unsigned ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_v,
  input  logic signed [ACC_W-1:0] in_acc,
  input  logic signed [W-1:0]     in_off,
  output logic                    out_v,
  output logic [W-1:0]            out_product
);
  localparam logic [W-1:0] MID     = W'(1) << (W-1);
  localparam logic [W-1:0] MAX_OUT = {{(W-1){1'b1}}, 1'b0};
  localparam longint ACC_LOW  = -(longint'(1) << (W-1)) * ((longint'(1) << W) - 1);
  localparam longint ACC_HIGH = ((longint'(1) << (W-1)) - 1) * ((longint'(1) << W) - 1);

  // upper half of the sum is floor(sum / 2^W); flipping its top bit adds half scale
  function automatic logic [W-1:0] rescale(input logic signed [ACC_W-1:0] a);
    return {~a[ACC_W-1], a[ACC_W-2:W]};
  endfunction

  logic rst_seen;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst) begin
      out_v       <= 1'b0;
      out_product <= MID;
    end else begin
      out_v <= in_v;
      if (in_v) out_product <= rescale(in_acc);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_seen) begin
      assert_reset_clears_R5: assert (!out_v && out_product == MID);
    end
  end

  assert_out_range_R8: assert property (@(posedge clk) disable iff (rst)
    out_v |-> (out_product <= MAX_OUT));
  assert_acc_bounds_R8: assert property (@(posedge clk) disable iff (rst)
    in_v |-> (longint'(in_acc) >= ACC_LOW && longint'(in_acc) <= ACC_HIGH));
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !in_v |=> $stable(out_product));
  assert_mid_carrier_R7: assert property (@(posedge clk) disable iff (rst)
    (in_v && in_off == '0) |=> (out_product == MID));
endmodule

// File: rtl/amod_pipe_mult.sv
module amod_pipe_mult #(
  parameter int unsigned DATA_W = amod_pkg::AMOD_SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              samp_valid,
  input  logic [DATA_W-1:0] carrier_in,
  input  logic [DATA_W-1:0] modulator_in,
  output logic              prod_valid,
  output logic [DATA_W-1:0] prod_sample
);
  localparam int unsigned ACC_W  = 2 * DATA_W;
  localparam int unsigned STAGES = DATA_W;

  logic                    stage_v    [0:STAGES];
  logic signed [ACC_W-1:0] stage_acc  [0:STAGES];
  logic signed [DATA_W-1:0] stage_off [0:STAGES];
  logic [DATA_W-1:0]       stage_mrem [0:STAGES];

  amod_offset_conv #(.W(DATA_W)) u_conv (
    .carrier (carrier_in),
    .offset  (stage_off[0])
  );

  assign stage_v[0]    = samp_valid;
  assign stage_acc[0]  = '0;
  assign stage_mrem[0] = modulator_in;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    amod_mac_stage #(.W(DATA_W), .ACC_W(ACC_W), .BIT(k)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .in_v     (stage_v[k]),
      .in_acc   (stage_acc[k]),
      .in_off   (stage_off[k]),
      .in_mrem  (stage_mrem[k]),
      .out_v    (stage_v[k+1]),
      .out_acc  (stage_acc[k+1]),
      .out_off  (stage_off[k+1]),
      .out_mrem (stage_mrem[k+1])
    );
  end

  amod_rescale_out #(.W(DATA_W), .ACC_W(ACC_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .in_v        (stage_v[STAGES]),
    .in_acc      (stage_acc[STAGES]),
    .in_off      (stage_off[STAGES]),
    .out_v       (prod_valid),
    .out_product (prod_sample)
  );

  assert_bits_consumed_R1: assert property (@(posedge clk) disable iff (rst)
    stage_v[STAGES] |-> (stage_mrem[STAGES] == '0));
endmodule

// File: tb/amod_pipe_mult_tb.sv
module amod_pipe_mult_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 13;
  localparam int NVEC       = 16;
  localparam int MAXQ       = 128;

  // each entry: {carrier, modulator}
  localparam logic [23:0] VEC [NVEC] = '{
    {12'd0,    12'd4095},  // R8 bottom corner
    {12'd4095, 12'd4095},  // R8 top corner
    {12'd2048, 12'd3333},  // R7
    {12'd3999, 12'd0},     // R6
    {12'd0,    12'd1},     // R1 floor of -0.5
    {12'd4095, 12'd1},
    {12'd3000, 12'd2048},
    {12'd1000, 12'd3000},
    {12'd2049, 12'd4095},
    {12'd2047, 12'd4095},  // R1 floor of negative fraction
    {12'd4095, 12'd2048},
    {12'd0,    12'd2048},
    {12'd1234, 12'd777},
    {12'd3500, 12'd100},
    {12'd4000, 12'd4000},
    {12'd17,   12'd0}      // R6
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic samp_valid = 1'b0;
  logic [11:0] carrier_in = '0;
  logic [11:0] modulator_in = '0;
  logic prod_valid;
  logic [11:0] prod_sample;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wr_idx = 0;
  int rd_idx = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  int exp_val [MAXQ];
  int exp_cyc [MAXQ];
  string exp_tag [MAXQ];

  amod_pipe_mult dut_i (
    .clk          (clk),
    .rst          (rst),
    .samp_valid   (samp_valid),
    .carrier_in   (carrier_in),
    .modulator_in (modulator_in),
    .prod_valid   (prod_valid),
    .prod_sample  (prod_sample)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int model(input int c, input int m);
    int p, q;
    p = (c - 2048) * m;
    q = p / 4096;
    if (p < 0 && (p % 4096) != 0) q = q - 1;
    return 2048 + q;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic send(input int c, input int m, input string tag);
    @(negedge clk);
    samp_valid   = 1'b1;
    carrier_in   = 12'(c);
    modulator_in = 12'(m);
    exp_val[wr_idx % MAXQ] = model(c, m);
    exp_cyc[wr_idx % MAXQ] = cyc;
    exp_tag[wr_idx % MAXQ] = tag;
    wr_idx++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      samp_valid   = 1'b0;
      carrier_in   = 12'(i * 37 + 5);
      modulator_in = 12'(i * 91 + 3);
    end
  endtask

  // scoreboard: value (R1), latency (R2), ordering (R3), no extra results (R4)
  always @(negedge clk) begin
    if (mon_en && !rst && prod_valid) begin
      if (rd_idx >= wr_idx) begin
        check(1'b0, "R4 unexpected result", int'(prod_sample), -1);
      end else begin
        check(int'(prod_sample) == exp_val[rd_idx % MAXQ], exp_tag[rd_idx % MAXQ],
              int'(prod_sample), exp_val[rd_idx % MAXQ]);
        check(cyc - exp_cyc[rd_idx % MAXQ] == LAT, "R2 latency",
              cyc - exp_cyc[rd_idx % MAXQ], LAT);
        rd_idx++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    logic [11:0] held;
    repeat (3) @(negedge clk);
    // R5: reset state
    check(prod_valid == 1'b0, "R5 valid in reset", int'(prod_valid), 0);
    check(prod_sample == 12'd2048, "R5 product in reset", int'(prod_sample), 2048);
    @(negedge clk);
    rst = 1'b0;
    mon_en = 1'b1;

    // R1/R3/R6/R7/R8: back-to-back stream of the table
    for (int i = 0; i < NVEC; i++)
      send(int'(VEC[i][23:12]), int'(VEC[i][11:0]), "R1 R3 R6 R7 R8 table value");
    idle(LAT + 3);
    check(rd_idx == wr_idx, "R3 results returned", rd_idx, wr_idx);

    // R4: gaps between samples
    send(100, 4095, "R4 gapped value");
    idle(3);
    send(4095, 4095, "R8 gapped top corner");
    idle(1);
    send(0, 4095, "R8 gapped bottom corner");
    send(2048, 4095, "R7 gapped midpoint");
    idle(2);
    send(3071, 0, "R6 gapped zero gain");
    idle(LAT + 3);
    check(rd_idx == wr_idx, "R4 result count", rd_idx, wr_idx);

    // R9: output holds while idle
    held = prod_sample;
    check(held == 12'd2048, "R9 last value", int'(held), 2048);
    idle(6);
    check(prod_sample == held, "R9 hold while idle", int'(prod_sample), int'(held));

    // R5: reset with samples in flight
    send(4000, 4000, "R5 flushed");
    send(10, 3000, "R5 flushed");
    send(3500, 1500, "R5 flushed");
    @(negedge clk);
    samp_valid = 1'b0;
    mon_en = 1'b0;
    rst = 1'b1;
    idle(2);
    rd_idx = wr_idx;
    rst = 1'b0;
    mon_en = 1'b1;
    for (int i = 0; i < LAT + 4; i++) begin
      @(negedge clk);
      if (prod_valid || prod_sample != 12'd2048)
        check(1'b0, "R5 flush", int'(prod_sample), 2048);
    end
    check(prod_valid == 1'b0, "R5 no stale result", int'(prod_valid), 0);
    check(prod_sample == 12'd2048, "R5 product after flush", int'(prod_sample), 2048);

    // R1: operation resumes after reset
    send(3333, 1111, "R1 after reset");
    send(1, 4094, "R1 after reset");
    idle(LAT + 3);
    check(rd_idx == wr_idx, "R3 results after reset", rd_idx, wr_idx);

    done = 1'b1;
    finish_run();
  end
endmodule